// File: doc/BRIEF.md
# Converter Parallel Bus Interface Controller

This block is the digital front end of an eight-channel, 12-bit successive-approximation converter that a microprocessor sees on one shared byte-wide bus. The processor writes a single control byte. The block decodes that byte into controls for the analog core: the mux channel, the full-scale range, unipolar or bipolar coding, the timing of acquisition, the conversion clock source and the power state. A 12-bit digital stand-in port takes the place of the sampled analog level.

After a write, the block tracks the input. Tracking lasts a fixed six cycles, or it continues until a later write with the external-acquisition bit clear. The block then holds the level and runs a twelve-step successive-approximation search. When the search is done it pulls an active-low interrupt. The processor reads the 12-bit result as two bytes, and a high-byte enable picks which one. The bus output is enabled only during a selected read. The bus signals are sampled synchronously, and a strobe acts at the cycle it first becomes active.

Top module: `conv_bus_ctrl`

## Requirements
- R1: A write is taken on the first clock in which cs_n and wr_n are both low. The byte is bit 7 PD1, bit 6 PD0, bit 5 external-acquisition, bit 4 range, bit 3 bipolar and bits 2..0 channel. mux_sel shows bits 2..0. After reset all settings are 0, int_n is 1 and track is 0.
- R2: range_full shows bit 4 (1 = full reference span). bipolar shows bit 3 (1 = bipolar).
- R3: Bits 7..6 give the mode: 00 normal with external conversion clock, 01 normal with internal clock, 10 standby (pwr_standby=1), 11 full power-down (pwr_full=1). int_clk_mode follows bit 6 only when bit 7 is 0, so the clock mode is kept through power-down.
- R4: A normal-mode write with bit 5 = 0 raises track for exactly 6 cycles. After that the level is held and conversion starts.
- R5: A normal-mode write with bit 5 = 1 keeps track high. A later write with bit 5 = 0 ends tracking and starts conversion at once.
- R6: Conversion takes 12 steps. In internal clock mode there is one step per clock, so int_n falls 12 cycles after track drops. In external clock mode there is one step per clock with ext_step high, and int_n stays high without those pulses.
- R7: A write with bit 7 = 1 stops any acquisition or conversion. In power-down, track stays 0, no conversion starts and int_n keeps its value.
- R8: The result equals the held level in unipolar mode. In bipolar mode it equals the level with bit 11 inverted, which turns offset binary into two's complement.
- R9: A read with cs_n and rd_n low drives data_oe. With hben = 0, data_o is result[7:0]. With hben = 1, data_o[3:0] is result[11:8] and data_o[7:4] is 0 in unipolar mode or copies of result[11] in bipolar mode.
- R10: While cs_n is high, data_oe is 0 and wr_n and rd_n have no effect.
- R11: int_n returns high at the start of a read access or at the start of a new acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | High-byte enable for reads |
| data_i | input | 8 | Bus value seen by the block |
| data_o | output | 8 | Bus value driven by the block |
| data_oe | output | 1 | Bus drive enable (0 = high impedance) |
| sample_i | input | 12 | Stand-in for the sampled analog level |
| ext_step | input | 1 | Conversion step enable in external clock mode |
| mux_sel | output | 3 | Selected input channel |
| range_full | output | 1 | Full-reference span selected |
| bipolar | output | 1 | Bipolar coding selected |
| int_clk_mode | output | 1 | Internal conversion clock selected |
| pwr_standby | output | 1 | Standby power-down active |
| pwr_full | output | 1 | Full power-down active |
| track | output | 1 | Input tracking (acquisition) active |
| int_n | output | 1 | Conversion done, active low |

## Verification
The bench measures how long track stays high and how long a conversion runs. A counter that is off by one would show up as 5 or 7 tracking cycles, or as an early interrupt. It reads the high byte in both codings, so a fill of zeros where sign copies belong (or the reverse) shows in bits 7..4. It writes in standby and in full power-down and confirms that track never rises and a pending interrupt is kept. It also aborts an open acquisition. It toggles the strobes with chip select high, and a design that did not gate them would change mux_sel or drive the bus.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int BUS_W = 8;
    localparam int RES_W = 12;
    localparam int HI_W  = RES_W - BUS_W;
    localparam int CH_W  = 3;

    typedef enum logic [1:0] {
        PM_NORM_EXT = 2'b00,
        PM_NORM_INT = 2'b01,
        PM_STANDBY  = 2'b10,
        PM_FULL     = 2'b11
    } pmode_e;

    // Field order follows the control byte, MSB first.
    typedef struct packed {
        pmode_e             pm;
        logic               acq_ext;
        logic               rng_full;
        logic               bip;
        logic [CH_W-1:0]    ch;
    } ctrl_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ACQ_INT,
        SQ_ACQ_EXT,
        SQ_CONV
    } seq_e;

    function automatic ctrl_t unpack_ctrl(input logic [BUS_W-1:0] b);
        return ctrl_t'(b);
    endfunction

    function automatic logic [RES_W-1:0] fmt_code(input logic [RES_W-1:0] level,
                                                   input logic bip);
        return bip ? (level ^ {1'b1, {(RES_W-1){1'b0}}}) : level;
    endfunction

    function automatic logic [BUS_W-1:0] hi_byte(input logic [RES_W-1:0] r,
                                                  input logic bip);
        return {{(BUS_W-HI_W){bip & r[RES_W-1]}}, r[RES_W-1:BUS_W]};
    endfunction

endpackage

// File: rtl/cbc_bus_if.sv
module cbc_bus_if
    import cbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic [RES_W-1:0] result,
    input  logic             res_bip,
    output logic             wr_pulse,
    output logic             rd_pulse,
    output logic [BUS_W-1:0] data_o,
    output logic             data_oe
);
    logic wr_act, rd_act, wr_q, rd_q;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_pulse = wr_act && !wr_q;
    assign rd_pulse = rd_act && !rd_q;
    assign data_oe  = rd_act;

    always_comb begin
        if (!rd_act)
            data_o = '0;
        else if (hben)
            data_o = hi_byte(result, res_bip);
        else
            data_o = result[BUS_W-1:0];
    end
endmodule

// File: rtl/cbc_ctrl_reg.sv
module cbc_ctrl_reg
    import cbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_pulse,
    input  logic [BUS_W-1:0] data_i,
    output ctrl_t            ctrl_q,
    output ctrl_t            ctrl_new,
    output logic             clk_int_q
);
    assign ctrl_new = unpack_ctrl(data_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            clk_int_q <= 1'b0;
        end else if (wr_pulse) begin
            ctrl_q <= ctrl_new;
            // Power-down codes leave the clock source untouched.
            if (!ctrl_new.pm[1])
                clk_int_q <= ctrl_new.pm[0];
        end
    end
endmodule

// File: rtl/cbc_seq.sv
module cbc_seq
    import cbc_pkg::*;
#(
    parameter int ACQ_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_pulse,
    input  logic             rd_pulse,
    input  ctrl_t            ctrl_new,
    input  ctrl_t            ctrl_cur,
    input  logic             clk_int,
    input  logic             ext_step,
    input  logic [RES_W-1:0] sample_i,
    output logic             track,
    output logic             int_n,
    output logic [RES_W-1:0] result,
    output logic             res_bip
);
    localparam int CW = $clog2(ACQ_CYC + 1);
    localparam int IW = $clog2(RES_W);

    seq_e             st;
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    idx;
    logic [RES_W-1:0] hold_q, sar_q, trial, sar_nxt;
    logic             conv_bip;
    logic             step;

    assign trial   = sar_q | (RES_W'(1) << idx);
    assign sar_nxt = (trial <= hold_q) ? trial : sar_q;
    assign step    = clk_int || ext_step;
    assign track   = (st == SQ_ACQ_INT) || (st == SQ_ACQ_EXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            cnt      <= '0;
            idx      <= '0;
            hold_q   <= '0;
            sar_q    <= '0;
            conv_bip <= 1'b0;
            result   <= '0;
            res_bip  <= 1'b0;
            int_n    <= 1'b1;
        end else begin
            if (rd_pulse)
                int_n <= 1'b1;
            if (wr_pulse && ctrl_new.pm[1]) begin
                st <= SQ_IDLE;
            end else if (wr_pulse && st != SQ_CONV) begin
                if (st == SQ_ACQ_EXT && ctrl_cur.acq_ext && !ctrl_new.acq_ext) begin
                    st       <= SQ_CONV;
                    hold_q   <= sample_i;
                    sar_q    <= '0;
                    idx      <= IW'(RES_W - 1);
                    conv_bip <= ctrl_new.bip;
                end else begin
                    st    <= ctrl_new.acq_ext ? SQ_ACQ_EXT : SQ_ACQ_INT;
                    cnt   <= '0;
                    int_n <= 1'b1;
                end
            end else begin
                case (st)
                    SQ_ACQ_INT: begin
                        if (cnt == CW'(ACQ_CYC - 1)) begin
                            st       <= SQ_CONV;
                            hold_q   <= sample_i;
                            sar_q    <= '0;
                            idx      <= IW'(RES_W - 1);
                            conv_bip <= ctrl_cur.bip;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SQ_CONV: begin
                        if (step) begin
                            sar_q <= sar_nxt;
                            if (idx == '0) begin
                                st      <= SQ_IDLE;
                                result  <= fmt_code(sar_nxt, conv_bip);
                                res_bip <= conv_bip;
                                int_n   <= 1'b0;
                            end else begin
                                idx <= idx - 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/conv_bus_ctrl.sv
module conv_bus_ctrl
    import cbc_pkg::*;
#(
    parameter int ACQ_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic [BUS_W-1:0] data_i,
    output logic [BUS_W-1:0] data_o,
    output logic             data_oe,
    input  logic [RES_W-1:0] sample_i,
    input  logic             ext_step,
    output logic [CH_W-1:0]  mux_sel,
    output logic             range_full,
    output logic             bipolar,
    output logic             int_clk_mode,
    output logic             pwr_standby,
    output logic             pwr_full,
    output logic             track,
    output logic             int_n
);
    logic             wr_pulse, rd_pulse, clk_int, res_bip;
    ctrl_t            ctrl_q, ctrl_new;
    logic [RES_W-1:0] result;

    cbc_bus_if u_bus (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .hben(hben), .result(result), .res_bip(res_bip),
        .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
        .data_o(data_o), .data_oe(data_oe)
    );

    cbc_ctrl_reg u_reg (
        .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .data_i(data_i),
        .ctrl_q(ctrl_q), .ctrl_new(ctrl_new), .clk_int_q(clk_int)
    );

    cbc_seq #(.ACQ_CYC(ACQ_CYC)) u_seq (
        .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
        .ctrl_new(ctrl_new), .ctrl_cur(ctrl_q), .clk_int(clk_int),
        .ext_step(ext_step), .sample_i(sample_i),
        .track(track), .int_n(int_n), .result(result), .res_bip(res_bip)
    );

    assign mux_sel      = ctrl_q.ch;
    assign range_full   = ctrl_q.rng_full;
    assign bipolar      = ctrl_q.bip;
    assign int_clk_mode = clk_int;
    assign pwr_standby  = (ctrl_q.pm == PM_STANDBY);
    assign pwr_full     = (ctrl_q.pm == PM_FULL);
endmodule

// File: rtl/conv_bus_ctrl_chk.sv
module conv_bus_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       hben,
    input logic [7:0] data_o,
    input logic       data_oe,
    input logic       pwr_standby,
    input logic       pwr_full,
    input logic       track,
    input logic       int_n
);
    a_r10_bus_released: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !data_oe);

    a_r7_no_track_in_pd: assert property (@(posedge clk) disable iff (rst)
        (pwr_standby || pwr_full) |-> !track);

    a_r9_upper_fill: assert property (@(posedge clk) disable iff (rst)
        (data_oe && hben) |-> (data_o[7:4] == 4'h0 || data_o[7:4] == {4{data_o[3]}}));

    a_r6_done_after_conv: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> !$past(track));

    a_r11_acq_clears_int: assert property (@(posedge clk) disable iff (rst)
        $rose(track) |-> int_n);
endmodule

bind conv_bus_ctrl conv_bus_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .hben(hben), .data_o(data_o),
    .data_oe(data_oe), .pwr_standby(pwr_standby), .pwr_full(pwr_full),
    .track(track), .int_n(int_n)
);

// File: tb/conv_bus_ctrl_tb_top.sv
module conv_bus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0;
    logic [7:0]  data_i = 8'h00;
    logic [7:0]  data_o;
    logic        data_oe;
    logic [11:0] sample_i = 12'h000;
    logic        ext_step = 1'b0;
    logic [2:0]  mux_sel;
    logic        range_full, bipolar, int_clk_mode, pwr_standby, pwr_full, track, int_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    conv_bus_ctrl dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .hben(hben), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
        .sample_i(sample_i), .ext_step(ext_step), .mux_sel(mux_sel),
        .range_full(range_full), .bipolar(bipolar), .int_clk_mode(int_clk_mode),
        .pwr_standby(pwr_standby), .pwr_full(pwr_full), .track(track), .int_n(int_n)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); cs_n = 0; wr_n = 0; data_i = b;
        @(negedge clk); cs_n = 1; wr_n = 1;
    endtask

    task automatic rd_byte(input logic hb, output logic [7:0] v, output logic oe);
        @(negedge clk); cs_n = 0; rd_n = 0; hben = hb;
        #1; v = data_o; oe = data_oe;
        @(negedge clk); cs_n = 1; rd_n = 1; hben = 0;
    endtask

    task automatic track_len(output int n);
        n = 0;
        while (track && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic conv_len(output int n);
        n = 0;
        while (int_n && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic read_pair(input string req, input logic [7:0] lo_e, input logic [7:0] hi_e);
        logic [7:0] v; logic oe;
        rd_byte(1'b0, v, oe);
        chk(oe && v == lo_e, req, v, lo_e);
        rd_byte(1'b1, v, oe);
        chk(oe && v == hi_e, req, v, hi_e);
    endtask

    task automatic t_reset;
        chk(int_n == 1 && track == 0 && data_oe == 0, "R1 reset outputs", {int_n, track, data_oe}, 3'b100);
        chk(mux_sel == 0 && !range_full && !bipolar && !int_clk_mode && !pwr_standby && !pwr_full,
            "R1 reset settings", {mux_sel, range_full, bipolar, int_clk_mode, pwr_standby, pwr_full}, 0);
    endtask

    task automatic t_decode_ext_acq;
        int n;
        sample_i = 12'hABC;
        wr_byte(8'h75);
        chk(mux_sel == 3'd5, "R1 channel field", mux_sel, 5);
        chk(range_full == 1 && bipolar == 0, "R2 range/polarity", {range_full, bipolar}, 2'b10);
        chk(int_clk_mode == 1 && !pwr_standby && !pwr_full, "R3 normal internal clock", int_clk_mode, 1);
        repeat (20) @(negedge clk);
        chk(track == 1, "R5 tracking held", track, 1);
        wr_byte(8'h6A);
        chk(mux_sel == 3'd2 && range_full == 0 && bipolar == 1, "R2 second byte",
            {mux_sel, range_full, bipolar}, 5'b01001);
        chk(track == 1, "R5 still tracking", track, 1);
        wr_byte(8'h42);
        chk(track == 0, "R5 write ends tracking", track, 0);
        conv_len(n);
        chk(n == 12, "R6 internal conversion length", n, 12);
        read_pair("R8 R9 unipolar", 8'hBC, 8'h0A);
        chk(int_n == 1, "R11 read clears int_n", int_n, 1);
    endtask

    task automatic t_int_acq_bipolar;
        int n;
        sample_i = 12'h123;
        wr_byte(8'h48);
        track_len(n);
        chk(n == 6, "R4 acquisition length", n, 6);
        conv_len(n);
        chk(n == 12, "R6 conversion after acq", n, 12);
        read_pair("R8 R9 bipolar negative", 8'h23, 8'hF9);
        sample_i = 12'h923;
        wr_byte(8'h4B);
        track_len(n);
        conv_len(n);
        read_pair("R8 R9 bipolar positive", 8'h23, 8'h01);
    endtask

    task automatic t_ext_clock;
        int n;
        sample_i = 12'h555;
        wr_byte(8'h01);
        chk(int_clk_mode == 0 && mux_sel == 3'd1, "R3 external clock", int_clk_mode, 0);
        track_len(n);
        chk(n == 6, "R4 acquisition length ext clk", n, 6);
        repeat (20) @(negedge clk);
        chk(int_n == 1, "R6 waits for ext_step", int_n, 1);
        ext_step = 1;
        repeat (11) @(negedge clk);
        chk(int_n == 1, "R6 eleven steps not done", int_n, 1);
        @(negedge clk); ext_step = 0;
        chk(int_n == 0, "R6 done after twelve steps", int_n, 0);
        read_pair("R8 R9 ext clock result", 8'h55, 8'h05);
    endtask

    task automatic t_powerdown;
        int n; int seen;
        sample_i = 12'h0F0;
        wr_byte(8'h40);
        track_len(n);
        conv_len(n);
        chk(int_n == 0, "R6 done before pd", int_n, 0);
        wr_byte(8'h80);
        chk(pwr_standby == 1 && pwr_full == 0, "R3 standby", {pwr_standby, pwr_full}, 2'b10);
        chk(int_clk_mode == 1, "R3 clock mode kept", int_clk_mode, 1);
        seen = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (track) seen++; end
        chk(seen == 0, "R7 no acquisition in standby", seen, 0);
        chk(int_n == 0, "R7 int_n kept in pd", int_n, 0);
        wr_byte(8'hE5);
        chk(pwr_full == 1 && mux_sel == 3'd5 && track == 0, "R7 full pd write",
            {pwr_full, mux_sel, track}, 5'b11010);
        read_pair("R9 read in pd", 8'hF0, 8'h00);
        wr_byte(8'h61);
        chk(track == 1 && !pwr_full && int_clk_mode == 1, "R3 wake", {track, pwr_full}, 2'b10);
        wr_byte(8'h80);
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (track || !int_n) seen++; end
        chk(seen == 0, "R7 abort by pd", seen, 0);
    endtask

    task automatic t_cs_high;
        logic [2:0] m; logic t;
        wr_byte(8'h03);
        m = mux_sel; t = track;
        @(negedge clk); cs_n = 1; wr_n = 0; data_i = 8'h07;
        repeat (3) @(negedge clk);
        chk(mux_sel == m && track == t, "R10 write ignored", mux_sel, m);
        wr_n = 1; rd_n = 0; #1;
        chk(data_oe == 0, "R10 bus released", data_oe, 0);
        @(negedge clk); rd_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_decode_ext_acq;
        t_int_acq_bipolar;
        t_ext_clock;
        t_powerdown;
        t_cs_high;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule